// File: doc/BRIEF.md
# Return-to-Zero Word Transmitter with Eight-Word Queue

This block takes 31-bit avionics data words from a 16-bit host bus and sends each one as a 32-bit serial frame. A word is written in two strobes, first half then second half, and goes into an eight-entry queue. While the enable input is high, the block pops words in order. Each word goes out with a generated parity bit in position 32, on two return-to-zero lines: one line pulses for a 1 and the other pulses for a 0.

The bit period is either 10 or 80 master clocks, chosen by a speed input. The first half of each period carries data and the second half is null. Consecutive words are separated by four null bit periods. A ready flag shows when the queue is empty and nothing is on the line. A free-running bit clock output runs at the selected bit rate.

Top module: `rz_word_xmit`

## Requirements
- R1: A pulse on `strobe_lo` captures the first half of the word, and a later pulse on `strobe_hi` completes it and queues it. In the first half, bus bits 7..0 become frame bits 1..8 (bus bit 7 is frame bit 1), bus bits 11..15 become frame bits 9..13, bus bit 9 becomes frame bit 30 and bus bit 10 becomes frame bit 31. Bus bit 8 has no effect. In the second half, bus bit i becomes frame bit 14+i. A `strobe_hi` with no pending first half queues nothing.
- R2: The queue holds 8 words. A word completed while the queue is full is dropped and never transmitted.
- R3: `tx_ready` is high after reset. It is low from the cycle after a word is queued. It returns high on the cycle after the last word's gap ends with the queue empty.
- R4: `bit_clk` is high for H master clocks and low for H, where H is 5 with `sel_slow`=0 and 40 with `sel_slow`=1.
- R5: Each frame bit is a data half of H clocks, in which exactly one line is high (`line_one` for 1, `line_zero` for 0), followed by H clocks with both lines low. Bits are sent in order from frame bit 1 to frame bit 32.
- R6: Frame bit 32 makes the total count of ones in the frame odd when `sel_even`=0 and even when `sel_even`=1.
- R7: When the block is idle with a queued word, a clock edge that samples `tx_enable` high starts frame bit 1 on the following cycle.
- R8: Between back-to-back frames, both lines stay low for exactly 4 bit periods (8·H clocks).
- R9: When `tx_enable` falls during a frame, that frame is discarded and both lines are low from the next cycle. The next enable sends the following queued word.
- R10: Reset stops output at once, drives both lines low, empties the queue and sets `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | 16 | Host data for either half of a word |
| strobe_lo | input | 1 | Captures the first half (one-cycle pulse) |
| strobe_hi | input | 1 | Captures the second half and queues the word |
| sel_even | input | 1 | Parity sense: 0 odd, 1 even |
| sel_slow | input | 1 | Speed: 0 divides by 10, 1 divides by 80 |
| tx_enable | input | 1 | Allows transmission |
| line_one | output | 1 | High during the data half of a 1 bit |
| line_zero | output | 1 | High during the data half of a 0 bit |
| tx_ready | output | 1 | Queue empty and line idle |
| bit_clk | output | 1 | Free-running clock at the bit rate |

## Verification
Every output is decoded from state registers, so each result is due exactly one clock after the edge that samples its cause. A completed second strobe lowers `tx_ready` one cycle later. An enable seen with a queued word shows frame bit 1 on the next cycle. A falling enable silences both lines one cycle later. The end of the last gap raises `tx_ready` on the cycle after the gap's final clock. The bench drives inputs and samples outputs on falling edges, then counts exact half-bit and gap windows from those points. A single clock of skew in any of these windows is reported as a timing failure.

// File: rtl/rzx_pkg.sv
package rzx_pkg;
  localparam int PAYLOAD_W = 31;
  typedef logic [PAYLOAD_W-1:0] payload_t;

  // index k-1 holds frame bit k
  function automatic payload_t first_half_bits(input logic [15:0] d);
    payload_t w;
    w = '0;
    for (int i = 0; i < 8; i++) w[i] = d[7-i];
    for (int j = 0; j < 5; j++) w[8+j] = d[11+j];
    w[29] = d[9];
    w[30] = d[10];
    return w;
  endfunction

  function automatic payload_t second_half_bits(input logic [15:0] d);
    payload_t w;
    w = '0;
    for (int i = 0; i < 16; i++) w[13+i] = d[i];
    return w;
  endfunction

  function automatic logic parity_bit(input payload_t w, input logic even);
    return (^w) ^ ~even;
  endfunction
endpackage

// File: rtl/rzx_fifo.sv
module rzx_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 31
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               push_data,
  input  logic                       pop,
  output logic [W-1:0]               head,
  output logic                       empty,
  output logic                       full,
  output logic [$clog2(DEPTH+1)-1:0] fill
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (fill == '0);
  assign full    = (fill == FW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      fill <= fill + FW'(do_push) - FW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= push_data;
  end

  a_r2_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop) |=> full);
  a_r2_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= FW'(DEPTH));
endmodule

// File: rtl/rzx_bitclk.sv
module rzx_bitclk #(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slow,
  output logic bit_clk
);
  localparam int MAXD = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int CW   = $clog2(MAXD);

  logic [CW-1:0] cnt, lim, half;

  assign lim     = slow ? CW'(SLOW_DIV-1) : CW'(FAST_DIV-1);
  assign half    = slow ? CW'(SLOW_DIV/2) : CW'(FAST_DIV/2);
  assign bit_clk = (cnt < half);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (cnt >= lim) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rzx_serial.sv
module rzx_serial #(
  parameter int FAST_DIV = 10,
  parameter int SLOW_DIV = 80,
  parameter int GAP_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              slow,
  input  logic              even,
  input  logic              head_valid,
  input  rzx_pkg::payload_t head_word,
  output logic              pop,
  output logic              busy,
  output logic              line_one,
  output logic              line_zero
);
  localparam int FRAME = rzx_pkg::PAYLOAD_W + 1;
  localparam int SLOTS = FRAME + GAP_BITS;
  localparam int SW    = $clog2(SLOTS);
  localparam int BW    = $clog2(FRAME);
  localparam int MAXD  = (FAST_DIV > SLOW_DIV) ? FAST_DIV : SLOW_DIV;
  localparam int CW    = $clog2(MAXD);

  logic [CW-1:0]    cnt, lim, half;
  logic [SW-1:0]    slot;
  logic [FRAME-1:0] frame;
  logic             slot_end, word_end, in_frame, data_half, cur_bit;

  assign lim       = slow ? CW'(SLOW_DIV-1) : CW'(FAST_DIV-1);
  assign half      = slow ? CW'(SLOW_DIV/2) : CW'(FAST_DIV/2);
  assign slot_end  = busy && (cnt >= lim);
  assign word_end  = slot_end && (slot == SW'(SLOTS-1));
  assign pop       = en && head_valid && (!busy || word_end);
  assign in_frame  = (slot < SW'(FRAME));
  assign data_half = busy && in_frame && (cnt < half);
  assign cur_bit   = frame[slot[BW-1:0]];
  assign line_one  = data_half && cur_bit;
  assign line_zero = data_half && !cur_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      slot  <= '0;
      frame <= '0;
    end else if (busy && !en) begin
      busy <= 1'b0;
    end else if (pop) begin
      busy  <= 1'b1;
      cnt   <= '0;
      slot  <= '0;
      frame <= {rzx_pkg::parity_bit(head_word, even), head_word};
    end else if (word_end) begin
      busy <= 1'b0;
    end else if (slot_end) begin
      cnt  <= '0;
      slot <= slot + 1'b1;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
    end
  end

  a_r5_one_line: assert property (@(posedge clk) disable iff (!rst_n)
    !(line_one && line_zero));
  a_r9_abort_null: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !en) |=> (!busy && !line_one && !line_zero));
  a_r8_gap_end_silent: assert property (@(posedge clk) disable iff (!rst_n)
    word_end |-> (!line_one && !line_zero));
endmodule

// File: rtl/rz_word_xmit.sv
module rz_word_xmit #(
  parameter int FIFO_DEPTH = 8,
  parameter int FAST_DIV   = 10,
  parameter int SLOW_DIV   = 80,
  parameter int GAP_BITS   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] bus_data,
  input  logic        strobe_lo,
  input  logic        strobe_hi,
  input  logic        sel_even,
  input  logic        sel_slow,
  input  logic        tx_enable,
  output logic        line_one,
  output logic        line_zero,
  output logic        tx_ready,
  output logic        bit_clk
);
  localparam int FW = $clog2(FIFO_DEPTH+1);

  rzx_pkg::payload_t stage, push_word, head_word;
  logic              lo_pend, push, pop, empty, full, busy;
  logic [FW-1:0]     fill;

  assign push      = strobe_hi && !strobe_lo && lo_pend;
  assign push_word = stage | rzx_pkg::second_half_bits(bus_data);
  assign tx_ready  = empty && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage   <= '0;
      lo_pend <= 1'b0;
    end else if (strobe_lo) begin
      stage   <= rzx_pkg::first_half_bits(bus_data);
      lo_pend <= 1'b1;
    end else if (strobe_hi) begin
      lo_pend <= 1'b0;
    end
  end

  rzx_fifo #(.DEPTH(FIFO_DEPTH), .W(rzx_pkg::PAYLOAD_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_word), .pop(pop),
    .head(head_word), .empty(empty), .full(full), .fill(fill)
  );

  rzx_serial #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .GAP_BITS(GAP_BITS)) u_ser (
    .clk(clk), .rst_n(rst_n), .en(tx_enable), .slow(sel_slow), .even(sel_even),
    .head_valid(!empty), .head_word(head_word), .pop(pop), .busy(busy),
    .line_one(line_one), .line_zero(line_zero)
  );

  rzx_bitclk #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_clk (
    .clk(clk), .rst_n(rst_n), .slow(sel_slow), .bit_clk(bit_clk)
  );

  a_r1_lone_second: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_hi && !strobe_lo && !lo_pend && !pop) |=> (fill == $past(fill)));
  a_r3_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full) |=> !tx_ready);
  a_r7_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: tb/sim_rz_word_xmit.sv
module sim_rz_word_xmit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] bus_data;
  logic        strobe_lo, strobe_hi, sel_even, sel_slow, tx_enable;
  logic        line_one, line_zero, tx_ready, bit_clk;
  int          checks = 0;
  int          errors = 0;

  always #4 clk = ~clk;

  rz_word_xmit u0 (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .strobe_lo(strobe_lo),
    .strobe_hi(strobe_hi), .sel_even(sel_even), .sel_slow(sel_slow),
    .tx_enable(tx_enable), .line_one(line_one), .line_zero(line_zero),
    .tx_ready(tx_ready), .bit_clk(bit_clk)
  );

  // {slow, even, first half, second half}
  localparam logic [33:0] VECS [6] = '{
    {1'b0, 1'b0, 16'hA5C3, 16'h1234},
    {1'b0, 1'b1, 16'hFFFF, 16'hFFFF},
    {1'b0, 1'b0, 16'h0000, 16'h0000},
    {1'b0, 1'b1, 16'h0100, 16'h0000},
    {1'b0, 1'b0, 16'h8001, 16'h8000},
    {1'b1, 1'b1, 16'h5A5A, 16'hC3C3}
  };

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // frame bit k sits at index k-1
  function automatic logic [31:0] expect_frame(input logic [15:0] lo, input logic [15:0] hi, input logic even);
    logic [31:0] f;
    f = '0;
    for (int k = 1; k <= 31; k++) begin
      if (k <= 8)       f[k-1] = lo[8-k];
      else if (k <= 13) f[k-1] = lo[k+2];
      else if (k <= 29) f[k-1] = hi[k-14];
      else              f[k-1] = lo[k-21];
    end
    f[31] = even ? ($countones(f[30:0]) % 2 == 1) : ($countones(f[30:0]) % 2 == 0);
    return f;
  endfunction

  task automatic load_word(input logic [15:0] lo, input logic [15:0] hi);
    @(negedge clk); bus_data = lo; strobe_lo = 1'b1;
    @(negedge clk); strobe_lo = 1'b0; bus_data = hi; strobe_hi = 1'b1;
    @(negedge clk); strobe_hi = 1'b0;
  endtask

  task automatic recv(input int half, input bit last, output logic [31:0] got, output int waited);
    int bad_data = 0;
    int bad_null = 0;
    int bad_gap  = 0;
    waited = 0;
    got    = '0;
    while (!(line_one || line_zero) && waited < 5000) begin
      @(negedge clk); waited++;
    end
    for (int b = 0; b < 32; b++) begin
      for (int c = 0; c < half; c++) begin
        if (c == 0) got[b] = line_one;
        if ((line_one == line_zero) || (line_one != got[b])) bad_data++;
        @(negedge clk);
      end
      for (int c = 0; c < half; c++) begin
        if (line_one || line_zero) bad_null++;
        @(negedge clk);
      end
    end
    for (int g = 0; g < 8*half; g++) begin
      if (line_one || line_zero) bad_gap++;
      @(negedge clk);
    end
    chk(bad_data == 0, "R5 data half one line", 64'(bad_data), 64'd0);
    chk(bad_null == 0, "R5 null half", 64'(bad_null), 64'd0);
    chk(bad_gap == 0, "R8 gap silent", 64'(bad_gap), 64'd0);
    if (last) chk(tx_ready, "R3 ready after last gap", 64'(tx_ready), 64'd1);
  endtask

  task automatic quiet(input int n, input string tag);
    int bad = 0;
    repeat (n) begin
      if (line_one || line_zero) bad++;
      @(negedge clk);
    end
    chk(bad == 0, tag, 64'(bad), 64'd0);
  endtask

  task automatic measure_clk(input int half);
    int hi_n = 0;
    int lo_n = 0;
    while (bit_clk) @(negedge clk);
    while (!bit_clk) @(negedge clk);
    while (bit_clk) begin hi_n++; @(negedge clk); end
    while (!bit_clk) begin lo_n++; @(negedge clk); end
    chk(hi_n == half && lo_n == half, "R4 bit clock halves", {32'(hi_n), 32'(lo_n)}, {32'(half), 32'(half)});
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] got, exp;
    logic [15:0] w_lo [9];
    logic [15:0] w_hi [9];
    int waited;
    rst_n = 1'b0; bus_data = '0; strobe_lo = 1'b0; strobe_hi = 1'b0;
    sel_even = 1'b0; sel_slow = 1'b0; tx_enable = 1'b0;
    repeat (3) @(negedge clk);
    chk(!line_one && !line_zero && tx_ready, "R10 reset state", {line_one, line_zero, tx_ready}, 3'b001);
    rst_n = 1'b1;
    @(negedge clk);

    measure_clk(5);
    sel_slow = 1'b1;
    measure_clk(40);
    sel_slow = 1'b0;

    // R1: second strobe with no pending first half
    @(negedge clk); bus_data = 16'hFFFF; strobe_hi = 1'b1;
    @(negedge clk); strobe_hi = 1'b0;
    @(negedge clk);
    chk(tx_ready, "R1 lone second strobe ignored", 64'(tx_ready), 64'd1);

    for (int v = 0; v < 6; v++) begin
      sel_slow = VECS[v][33];
      sel_even = VECS[v][32];
      load_word(VECS[v][31:16], VECS[v][15:0]);
      chk(!tx_ready, "R3 ready low after load", 64'(tx_ready), 64'd0);
      tx_enable = 1'b1;
      recv(sel_slow ? 40 : 5, 1'b1, got, waited);
      tx_enable = 1'b0;
      exp = expect_frame(VECS[v][31:16], VECS[v][15:0], sel_even);
      chk(waited == 1, "R7 start latency", 64'(waited), 64'd1);
      chk(got == exp, "R1 R5 frame content", 64'(got), 64'(exp));
      chk(($countones(got) % 2) == (sel_even ? 0 : 1), "R6 parity sense", 64'($countones(got)), 64'(!sel_even));
    end
    sel_slow = 1'b0; sel_even = 1'b0;

    // R2: nine loads into an eight-entry queue
    for (int i = 0; i < 9; i++) begin
      w_lo[i] = 16'h1111 * 16'(i + 1);
      w_hi[i] = ~(16'h0F0F + 16'(i));
      load_word(w_lo[i], w_hi[i]);
    end
    tx_enable = 1'b1;
    for (int i = 0; i < 8; i++) begin
      recv(5, i == 7, got, waited);
      exp = expect_frame(w_lo[i], w_hi[i], 1'b0);
      chk(got == exp, "R2 queued word order", 64'(got), 64'(exp));
      chk(waited == (i == 0 ? 1 : 0), "R8 back-to-back gap length", 64'(waited), 64'(i == 0));
    end
    quiet(200, "R2 ninth load dropped");
    tx_enable = 1'b0;

    // R9: enable drop mid-frame
    load_word(16'h3C3C, 16'h7777);
    load_word(16'h0F1E, 16'h2D3C);
    tx_enable = 1'b1;
    while (!(line_one || line_zero)) @(negedge clk);
    repeat (33) @(negedge clk);
    tx_enable = 1'b0;
    @(negedge clk);
    chk(!line_one && !line_zero && !tx_ready, "R9 abort to null", {line_one, line_zero, tx_ready}, 3'b000);
    quiet(20, "R9 stays null");
    tx_enable = 1'b1;
    recv(5, 1'b1, got, waited);
    tx_enable = 1'b0;
    exp = expect_frame(16'h0F1E, 16'h2D3C, 1'b0);
    chk(got == exp, "R9 aborted word discarded", 64'(got), 64'(exp));

    // R10: reset mid-frame
    load_word(16'hAAAA, 16'h5555);
    load_word(16'h1357, 16'h2468);
    tx_enable = 1'b1;
    while (!(line_one || line_zero)) @(negedge clk);
    repeat (7) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!line_one && !line_zero && tx_ready, "R10 reset stops output", {line_one, line_zero, tx_ready}, 3'b001);
    rst_n = 1'b1;
    quiet(300, "R10 queue cleared");
    chk(tx_ready, "R10 ready after reset", 64'(tx_ready), 64'd1);
    tx_enable = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule